// File: doc/BRIEF.md
# DDR3 Command Decoder with Bank Tracking

This block sits on the device side of a DDR3 link. On every rising clock edge it samples chip select, the three strobes RAS, CAS and WE (all active low), clock enable, the three-bit bank address and the fifteen-bit address bus. It combines the strobes with the address bits that change their meaning: A10 picks single-bank or all-bank precharge and carries auto-precharge on accesses, and A12 requests a burst chop. From this it produces one decoded command per cycle, together with the fields that go with it.

Eight bank slots each hold an open/idle flag and the row latched by the last activate. The decoder uses this state for three things: it flags accesses and activates that do not match the bank state, it refuses refresh while any row is open, and it tells precharge power-down from active power-down when clock enable falls. All outputs are registered and show the result of the command sampled on the previous rising edge.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, cmd_o is 0 (no operation), bank_active_o, err_o, pd_mode_o and all field outputs are 0.
- R2: When cs_ni is sampled high with clock enable steady high, cmd_o is 0 and no bank state changes, whatever the strobes carry.
- R3: With cs_ni low and clock enable steady high, the strobes {ras_ni,cas_ni,we_ni} decode as 000 mode-register-set (cmd 7), 001 refresh (6), 010 precharge (4, or 5 for all banks), 011 activate (1), 100 write (3), 101 read (2), others no operation (0). cmd_o shows the command one clock after its sampling edge.
- R4: An activate to an idle bank opens it, sets bit ba_i of bank_active_o and reports the 15-bit row on row_o. An activate to an open bank raises err_o and keeps the open row, which row_o reports.
- R5: A precharge with A10 low closes only bank ba_i (cmd 4). With A10 high it closes all banks (cmd 5).
- R6: A read or write to an open bank reports col_o = A9..A0, burst_chop_o = not A12, auto_pre_o = A10, and row_o = the bank's open row. With A10 high the bank becomes idle.
- R7: A read or write to an idle bank raises err_o and changes no bank state.
- R8: A refresh while all banks are idle reports cmd 6 without error. A refresh while any bank is open reports cmd 6 with err_o high.
- R9: A mode-register-set reports the mode register select (ba_i) on bank_o and the address bus on opcode_o.
- R10: Clock enable falling reports cmd 8 and sets pd_mode_o to 1 (precharge power-down) if all banks are idle, or 2 (active power-down) if any bank is open. While clock enable stays low all pins are ignored (cmd 0). Clock enable rising reports cmd 9 and pd_mode_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, inputs sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 3 | Bank address / mode register select |
| addr_i | input | 15 | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 3 | Target bank or mode register |
| row_o | output | 15 | Row of the target bank |
| col_o | output | 10 | Column for read/write |
| auto_pre_o | output | 1 | Auto-precharge on read/write |
| burst_chop_o | output | 1 | Burst chopped to 4 |
| opcode_o | output | 15 | Mode register opcode |
| err_o | output | 1 | Command conflicts with bank state |
| bank_active_o | output | 8 | Open flag per bank |
| pd_mode_o | output | 2 | Power-down kind: 0 none, 1 precharge, 2 active |

## Verification
Power-down entry and an ordinary command can fall in the same cycle, because clock enable falls on the same edge that the strobes are sampled. The bench opens one bank, then drops clock enable while the pins carry an activate to another bank. It expects cmd 8, active power-down, and an unchanged bank_active_o, which shows that the falling clock enable took priority and the activate was discarded.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PREA = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7,
    CMD_PDE  = 4'd8,
    CMD_PDX  = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    PD_NONE = 2'd0,
    PD_PRE  = 2'd1,
    PD_ACT  = 2'd2
  } pd_e;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import ddr3_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  input  logic cke_q_i,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_q_i && !cke_i)      cmd_o = CMD_PDE;   // entry beats any pin command
    else if (!cke_q_i && cke_i) cmd_o = CMD_PDX;
    else if (!cke_i)            cmd_o = CMD_NOP;
    else if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/bank_table.sv
module bank_table #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 15,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_one_i,
  input  logic              close_all_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [NB-1:0]     active_o,
  output logic              sel_active_o,
  output logic [ROW_W-1:0]  sel_row_o
);
  logic [ROW_W-1:0] rows [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             act_r;
    logic [ROW_W-1:0] row_r;
    logic             hit;
    assign hit = (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_r <= 1'b0;
        row_r <= '0;
      end else if (close_all_i || (close_one_i && hit)) begin
        act_r <= 1'b0;
      end else if (open_i && hit) begin
        act_r <= 1'b1;
        row_r <= row_i;
      end
    end

    assign active_o[b] = act_r;
    assign rows[b]     = row_r;
  end

  assign sel_active_o = active_o[bank_i];
  assign sel_row_o    = rows[bank_i];

  a_r5_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_all_i |=> (active_o == '0));
endmodule

// File: rtl/pd_tracker.sv
module pd_tracker
  import ddr3_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pde_i,
  input  logic       pdx_i,
  input  logic       any_active_i,
  output logic [1:0] pd_mode_o
);
  pd_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= PD_NONE;
    else if (pde_i)  mode_q <= any_active_i ? PD_ACT : PD_PRE;
    else if (pdx_i)  mode_q <= PD_NONE;
  end

  assign pd_mode_o = mode_q;

  a_r10_pd_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pde_i && any_active_i) |=> (pd_mode_o == PD_ACT));
endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 15,
  parameter int ROW_W  = 15,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              cke_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic              burst_chop_o,
  output logic [ADDR_W-1:0] opcode_o,
  output logic              err_o,
  output logic [NB-1:0]     bank_active_o,
  output logic [1:0]        pd_mode_o
);
  cmd_e             cmd;
  logic             cke_q;
  logic             sel_active;
  logic [ROW_W-1:0] sel_row;
  logic             is_rdwr, has_bank, err_c;
  logic             open_en, close_one, close_all;

  cmd_decode u_dec (
    .cs_ni   (cs_ni),
    .ras_ni  (ras_ni),
    .cas_ni  (cas_ni),
    .we_ni   (we_ni),
    .cke_i   (cke_i),
    .cke_q_i (cke_q),
    .a10_i   (addr_i[AP_BIT]),
    .cmd_o   (cmd)
  );

  assign is_rdwr   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign has_bank  = is_rdwr || (cmd == CMD_ACT) || (cmd == CMD_PRE) || (cmd == CMD_MRS);
  assign open_en   = (cmd == CMD_ACT) && !sel_active;
  assign close_one = (cmd == CMD_PRE) || (is_rdwr && sel_active && addr_i[AP_BIT]);
  assign close_all = (cmd == CMD_PREA);
  assign err_c     = ((cmd == CMD_ACT) && sel_active)
                   || (is_rdwr && !sel_active)
                   || ((cmd == CMD_REF) && (|bank_active_o));

  bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .open_i       (open_en),
    .close_one_i  (close_one),
    .close_all_i  (close_all),
    .bank_i       (ba_i),
    .row_i        (addr_i[ROW_W-1:0]),
    .active_o     (bank_active_o),
    .sel_active_o (sel_active),
    .sel_row_o    (sel_row)
  );

  pd_tracker u_pd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pde_i        (cmd == CMD_PDE),
    .pdx_i        (cmd == CMD_PDX),
    .any_active_i (|bank_active_o),
    .pd_mode_o    (pd_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q        <= 1'b1;
      cmd_o        <= CMD_NOP;
      bank_o       <= '0;
      row_o        <= '0;
      col_o        <= '0;
      auto_pre_o   <= 1'b0;
      burst_chop_o <= 1'b0;
      opcode_o     <= '0;
      err_o        <= 1'b0;
    end else begin
      cke_q        <= cke_i;
      cmd_o        <= cmd;
      bank_o       <= has_bank ? ba_i : '0;
      col_o        <= is_rdwr ? addr_i[COL_W-1:0] : '0;
      auto_pre_o   <= is_rdwr && addr_i[AP_BIT];
      burst_chop_o <= is_rdwr && !addr_i[BC_BIT];
      opcode_o     <= (cmd == CMD_MRS) ? addr_i : '0;
      err_o        <= err_c;
      if (cmd == CMD_ACT)              row_o <= sel_active ? sel_row : addr_i[ROW_W-1:0];
      else if (is_rdwr && sel_active)  row_o <= sel_row;
      else                             row_o <= '0;
    end
  end

  a_r2_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cke_q && cs_ni) |=> ((cmd_o == CMD_NOP) && $stable(bank_active_o)));

  a_r4_act_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_ACT) && !err_o) |-> bank_active_o[bank_o]);

  a_r8_ref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_REF) && !err_o) |-> (bank_active_o == '0));

  a_r7_idle_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) && err_o) |-> (row_o == '0));
endmodule

// File: tb/ddr3_cmd_decoder_tb.sv
module ddr3_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic [3:0]  cmd;
  logic [2:0]  bank;
  logic [14:0] row, opcode;
  logic [9:0]  col;
  logic        ap, bc, err;
  logic [7:0]  act;
  logic [1:0]  pd;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ddr3_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr), .cmd_o(cmd),
    .bank_o(bank), .row_o(row), .col_o(col), .auto_pre_o(ap),
    .burst_chop_o(bc), .opcode_o(opcode), .err_o(err),
    .bank_active_o(act), .pd_mode_o(pd)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive at negedge, result visible at the next negedge
  task automatic drive(logic c, logic r, logic a, logic w, logic k,
                       logic [2:0] b, logic [14:0] ad);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; ba = b; addr = ad;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cmd", cmd, 0);
    chk("R1 banks", act, 0);
    chk("R1 pd", pd, 0);
    chk("R1 err", err, 0);
    chk("R1 row", row, 0);
  endtask

  task automatic t_deselect;
    drive(1, 0, 1, 1, 1, 3'd3, 15'h0123);
    chk("R2 cmd", cmd, 0);
    chk("R2 banks", act, 0);
  endtask

  task automatic t_activate;
    drive(0, 0, 1, 1, 1, 3'd2, 15'h5A5A);
    chk("R3 act code", cmd, 1);
    chk("R4 bank", bank, 2);
    chk("R4 row", row, 15'h5A5A);
    chk("R4 open", act, 8'h04);
    drive(0, 0, 1, 1, 1, 3'd2, 15'h1111);
    chk("R4 double act err", err, 1);
    chk("R4 row kept", row, 15'h5A5A);
  endtask

  task automatic t_access;
    drive(0, 1, 0, 1, 1, 3'd2, 15'h02AB);       // read, A12=0, A10=0
    chk("R3 rd code", cmd, 2);
    chk("R6 col", col, 10'h2AB);
    chk("R6 chop", bc, 1);
    chk("R6 ap", ap, 0);
    chk("R6 row", row, 15'h5A5A);
    chk("R6 err", err, 0);
    drive(0, 1, 0, 0, 1, 3'd2, 15'h1555);       // write, A12=1, A10=1
    chk("R3 wr code", cmd, 3);
    chk("R6 no chop", bc, 0);
    chk("R6 ap set", ap, 1);
    chk("R6 ap closes", act, 0);
    drive(0, 1, 0, 1, 1, 3'd2, 15'h0001);
    chk("R7 idle rd err", err, 1);
    chk("R7 banks", act, 0);
  endtask

  task automatic t_precharge;
    drive(0, 0, 1, 1, 1, 3'd1, 15'h0010);
    drive(0, 0, 1, 1, 1, 3'd5, 15'h0020);
    drive(0, 0, 1, 0, 1, 3'd1, 15'h0000);
    chk("R5 pre code", cmd, 4);
    chk("R5 one closed", act, 8'h20);
    drive(0, 0, 0, 1, 1, 3'd0, 15'h0000);
    chk("R8 ref busy code", cmd, 6);
    chk("R8 ref busy err", err, 1);
    drive(0, 0, 1, 0, 1, 3'd0, 15'h0400);
    chk("R5 prea code", cmd, 5);
    chk("R5 all closed", act, 0);
    drive(0, 0, 0, 1, 1, 3'd0, 15'h0000);
    chk("R8 ref ok", err, 0);
  endtask

  task automatic t_mrs;
    drive(0, 0, 0, 0, 1, 3'd2, 15'h0A5C);
    chk("R9 code", cmd, 7);
    chk("R9 select", bank, 2);
    chk("R9 opcode", opcode, 15'h0A5C);
  endtask

  task automatic t_power;
    drive(0, 1, 1, 1, 0, 3'd0, 15'h0);
    chk("R10 pde code", cmd, 8);
    chk("R10 pre pd", pd, 1);
    drive(0, 0, 1, 1, 0, 3'd4, 15'h0077);
    chk("R10 ignored", cmd, 0);
    chk("R10 ignored banks", act, 0);
    drive(0, 1, 1, 1, 1, 3'd0, 15'h0);
    chk("R10 pdx code", cmd, 9);
    chk("R10 pd cleared", pd, 0);
    drive(0, 0, 1, 1, 1, 3'd0, 15'h0042);
    // entry collides with an activate on the pins
    drive(0, 0, 1, 1, 0, 3'd4, 15'h0099);
    chk("R10 collide code", cmd, 8);
    chk("R10 active pd", pd, 2);
    chk("R10 collide banks", act, 8'h01);
    drive(0, 1, 1, 1, 1, 3'd0, 15'h0);
    chk("R10 exit", pd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deselect();
    t_activate();
    t_access();
    t_precharge();
    t_mrs();
    t_power();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule